// File: doc/BRIEF.md
# Programmable Codec Clock Divider Chain

This block turns a single external master clock into the timing enables that a sampled-data codec needs. Three dividers sit in series. The master stage divides the master clock by 1, 2, 3, 4 or 5 to give an internal master tick. The serial stage divides that tick by 8, 4, 2 or 1 to give the serial bit clock. The sample stage divides the same tick by 2048, 1024, 512 or 256 to give a one-cycle frame strobe. Every output is either a one-cycle enable in the master clock domain or a registered serial-clock level, so downstream logic runs on one clock.

The three selects share one 8-bit control word, written through a strobe-and-data port. A written word waits in a pending register and is only copied into the live control word on a falling serial-clock event. When a write changes a divider field, the counters of that stage and of all later stages restart from phase zero. As a result the serial rise and the frame strobe stay aligned, and no stage runs with a count that was left over from an earlier ratio. Bit 7 is kept but has no effect on timing.

Top module: `codec_clkgen`

## Requirements
- R1: While `rst_n` is low `sclk_o` is low. After reset the control word is 0x00, so `mclk_en_o` pulses every cycle, `sclk_rise_o` every 8 cycles and `fs_strobe_o` every 2048 cycles.
- R2: Control bits 6:4 set the master ratio N. Codes 0 to 4 give N = code+1, and `mclk_en_o` pulses once every N cycles.
- R3: Master codes 5, 6 and 7 act as N = 1.
- R4: Control bits 3:2 set the serial ratio D (code 0→8, 1→4, 2→2, 3→1). `sclk_rise_o` pulses every N·D cycles.
- R5: Control bits 1:0 set the sample ratio M (code 0→2048, 1→1024, 2→512, 3→256). `fs_strobe_o` pulses every N·M cycles.
- R6: Every `fs_strobe_o` pulse falls in a cycle that also has `sclk_rise_o`.
- R7: For D ≥ 2, `sclk_fall_o` pulses N·D/2 cycles after each `sclk_rise_o`. `sclk_o` is high for the N·D/2 cycles that start the cycle after a rise, and low for the rest of the period. For D = 1, `sclk_fall_o` pulses in the same cycle as `sclk_rise_o` and `sclk_o` stays high.
- R8: A written word changes nothing until the first `sclk_fall_o` pulse from the cycle after the write onward. It becomes live from the next cycle. A later write made before that replaces the waiting word.
- R9: If an applied word changes bits 6:0, the next `mclk_en_o` pulse also carries `sclk_rise_o` and `fs_strobe_o`. That pulse comes in the cycle right after the fall if bits 6:4 changed. Otherwise it comes at the master stage's next regular pulse.
- R10: Applying a word whose bits 6:0 equal the live ones, including a change of bit 7 only, leaves the pulse trains undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Control word to write |
| mclk_en_o | output | 1 | Internal master clock enable pulse |
| sclk_o | output | 1 | Divided serial clock level |
| sclk_rise_o | output | 1 | Serial clock rising-event enable |
| sclk_fall_o | output | 1 | Serial clock falling-event enable |
| fs_strobe_o | output | 1 | One-cycle sample strobe |

## Verification
The pulse outputs are decoded from registered counters, so each one appears in the same cycle as the state that causes it. `sclk_o` follows one cycle after its rise or fall event. A written word becomes live at the edge that closes the cycle showing `sclk_fall_o`, so a restart is first visible one cycle after that fall when the master field changed. When the master field is unchanged and N = 2, the restart is first visible two cycles after the fall. The bench samples every output at the falling edge of `clk`, stamps each event with a counter that advances at the rising edge, and compares the distance between events with the expected counts. Around each applied write it checks the exact cycles t_f+1, t_f+2 and t_f+4 relative to the observed fall.

// File: rtl/codec_clkgen_pkg.sv
package codec_clkgen_pkg;

    localparam int CTRL_W = 8;   // control word width
    localparam int MCNT_W = 3;   // master stage counter width (ratio up to 5)
    localparam int SCNT_W = 3;   // serial stage counter width (ratio up to 8)
    localparam int FCNT_W = 11;  // sample stage counter width (ratio up to 2048)
    localparam int CFG_W  = 7;   // bits of the control word that affect timing

    // Live divider selects; packed so that bits 6:4, 3:2 and 1:0 of the word line up.
    typedef struct packed {
        logic [2:0] mdiv;
        logic [1:0] sdiv;
        logic [1:0] rate;
    } clk_cfg_t;

    function automatic logic [MCNT_W-1:0] mdiv_ratio(input logic [2:0] code);
        logic [MCNT_W-1:0] r;
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: r = MCNT_W'(code) + 1'b1;
            default:                      r = MCNT_W'(1);
        endcase
        return r;
    endfunction

    function automatic logic [SCNT_W:0] ser_ratio(input logic [1:0] code);
        logic [SCNT_W:0] top;
        top = (SCNT_W+1)'(1) << SCNT_W;
        return top >> code;
    endfunction

    function automatic logic [FCNT_W:0] smp_ratio(input logic [1:0] code);
        logic [FCNT_W:0] top;
        top = (FCNT_W+1)'(1) << FCNT_W;
        return top >> code;
    endfunction

endpackage

// File: rtl/codec_clkgen_cfg.sv
module codec_clkgen_cfg
    import codec_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              apply_en,
    output clk_cfg_t          cfg_o,
    output logic              restart_m_o,
    output logic              restart_p_o
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CTRL_W-1:0] pend;
        logic              vld;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic       do_apply;

    always_comb begin
        s_d      = s_q;
        do_apply = apply_en && s_q.vld;
        if (do_apply) begin
            s_d.ctrl = s_q.pend;
        end
        if (wr_en) begin
            s_d.pend = wr_data;
        end
        s_d.vld = do_apply ? wr_en : (s_q.vld || wr_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o       = clk_cfg_t'(s_q.ctrl[CFG_W-1:0]);
    assign restart_m_o = do_apply && (s_q.pend[CFG_W-1:4] != s_q.ctrl[CFG_W-1:4]);
    assign restart_p_o = do_apply && (s_q.pend[CFG_W-1:0] != s_q.ctrl[CFG_W-1:0]);

    // R8: the live word only moves after a falling serial event
    a_r8_ctrl_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.ctrl) |-> $past(apply_en));

    // R10: an unchanged timing field never restarts the chain
    a_r10_no_restart_same: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_p_o || restart_m_o) |=> !$stable(s_q.ctrl[CFG_W-1:0]));

endmodule

// File: rtl/codec_clkgen_mdiv.sv
module codec_clkgen_mdiv
    import codec_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] code,
    input  logic       restart,
    output logic       tick_o
);

    typedef struct packed {
        logic [MCNT_W-1:0] cnt;
    } mdiv_state_t;

    mdiv_state_t       s_d, s_q;
    logic [MCNT_W-1:0] ratio;

    always_comb begin
        s_d   = s_q;
        ratio = mdiv_ratio(code);
        if (restart) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= ratio - 1'b1) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = (s_q.cnt == '0);

    // R2: the phase never leaves the selected ratio
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < mdiv_ratio(code));

    // R9: a master restart yields a tick in the very next cycle
    a_r9_master_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> tick_o);

endmodule

// File: rtl/codec_clkgen_phase.sv
module codec_clkgen_phase
    import codec_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sdiv,
    input  logic [1:0] rate,
    input  logic       restart,
    output logic       rise_o,
    output logic       fall_o,
    output logic       strobe_o,
    output logic       sclk_o
);

    typedef struct packed {
        logic [SCNT_W-1:0] sc;
        logic [FCNT_W-1:0] fc;
        logic              sclk;
    } phase_state_t;

    phase_state_t      s_d, s_q;
    logic [SCNT_W:0]   d_ratio;
    logic [SCNT_W:0]   d_half;
    logic [FCNT_W:0]   m_ratio;

    always_comb begin
        d_ratio  = ser_ratio(sdiv);
        d_half   = d_ratio >> 1;
        m_ratio  = smp_ratio(rate);
        rise_o   = tick && (s_q.sc == '0);
        fall_o   = tick && ({1'b0, s_q.sc} == d_half);
        strobe_o = tick && (s_q.fc == '0);

        s_d = s_q;
        if (rise_o) begin
            s_d.sclk = 1'b1;
        end else if (fall_o) begin
            s_d.sclk = 1'b0;
        end
        if (restart) begin
            s_d.sc = '0;
            s_d.fc = '0;
        end else if (tick) begin
            s_d.sc = ({1'b0, s_q.sc} >= d_ratio - 1'b1) ? '0 : s_q.sc + 1'b1;
            s_d.fc = ({1'b0, s_q.fc} >= m_ratio - 1'b1) ? '0 : s_q.fc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o = s_q.sclk;

    // R6: frame strobe only on a serial rise
    a_r6_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> rise_o);

    // R7: the serial level is high the cycle after a rise
    a_r7_high_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> sclk_o);

    // R4: serial phase stays inside the selected ratio
    a_r4_sc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, s_q.sc} < ser_ratio(sdiv));

    // R9: a phase restart clears both downstream counters
    a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.sc == '0 && s_q.fc == '0));

endmodule

// File: rtl/codec_clkgen.sv
module codec_clkgen
    import codec_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              mclk_en_o,
    output logic              sclk_o,
    output logic              sclk_rise_o,
    output logic              sclk_fall_o,
    output logic              fs_strobe_o
);

    clk_cfg_t cfg;
    logic     restart_m;
    logic     restart_p;
    logic     dm_tick;
    logic     rise;
    logic     fall;
    logic     strobe;
    logic     sclk;

    codec_clkgen_cfg i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .apply_en    (fall),
        .cfg_o       (cfg),
        .restart_m_o (restart_m),
        .restart_p_o (restart_p)
    );

    codec_clkgen_mdiv i_mdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (cfg.mdiv),
        .restart (restart_m),
        .tick_o  (dm_tick)
    );

    codec_clkgen_phase i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (dm_tick),
        .sdiv     (cfg.sdiv),
        .rate     (cfg.rate),
        .restart  (restart_p),
        .rise_o   (rise),
        .fall_o   (fall),
        .strobe_o (strobe),
        .sclk_o   (sclk)
    );

    assign mclk_en_o   = dm_tick;
    assign sclk_o      = sclk;
    assign sclk_rise_o = rise;
    assign sclk_fall_o = fall;
    assign fs_strobe_o = strobe;

    // R5: the serial and frame events only occur on an internal master tick
    a_r5_events_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise_o || sclk_fall_o || fs_strobe_o) |-> mclk_en_o);

endmodule

// File: tb/test_codec_clkgen.sv
module test_codec_clkgen;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 30000;
    localparam int S_MCLK = 0;
    localparam int S_RISE = 1;
    localparam int S_FALL = 2;
    localparam int S_FS   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mclk_en_o;
    logic       sclk_o;
    logic       sclk_rise_o;
    logic       sclk_fall_o;
    logic       fs_strobe_o;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    codec_clkgen i_codec_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .mclk_en_o   (mclk_en_o),
        .sclk_o      (sclk_o),
        .sclk_rise_o (sclk_rise_o),
        .sclk_fall_o (sclk_fall_o),
        .fs_strobe_o (fs_strobe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic sig(input int sel);
        case (sel)
            S_MCLK:  return mclk_en_o;
            S_RISE:  return sclk_rise_o;
            S_FALL:  return sclk_fall_o;
            default: return fs_strobe_o;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_pulse(input int sel, output int t);
        int k;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!sig(sel) && k < WAIT_LIMIT);
        if (k >= WAIT_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: no pulse on output %0d, actual 0 expected 1", sel);
        end
        t = cyc;
    endtask

    task automatic meas(input int sel, output int d);
        int t1;
        int t2;
        wait_pulse(sel, t1);
        wait_pulse(sel, t2);
        d = t2 - t1;
    endtask

    // Write one word, then return the cycle stamp of the fall that applies it.
    task automatic wr_cfg(input logic [7:0] v, output int t_f);
        int k;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        k = 0;
        while (!sclk_fall_o && k < WAIT_LIMIT) begin
            @(negedge clk);
            k++;
        end
        if (k >= WAIT_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: no fall after write, actual 0 expected 1");
        end
        t_f = cyc;
    endtask

    task automatic t_reset();
        int d;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "sclk_o in reset", int'(sclk_o), 0);
        rst_n = 1'b1;
        meas(S_MCLK, d); chk("R1", "mclk interval", d, 1);
        meas(S_RISE, d); chk("R1", "rise interval", d, 8);
        meas(S_FS, d);   chk("R1", "strobe interval", d, 2048);
    endtask

    task automatic t_master();
        int d;
        int t_f;
        int n;
        for (int code = 0; code < 8; code++) begin
            wr_cfg({1'b0, 3'(code), 2'b11, 2'b11}, t_f);
            n = (code < 5) ? code + 1 : 1;
            meas(S_MCLK, d); chk((code < 5) ? "R2" : "R3", "mclk interval", d, n);
            meas(S_RISE, d); chk("R4", "rise interval D=1", d, n);
            meas(S_FS, d);   chk("R5", "strobe interval M=256", d, 256 * n);
        end
    endtask

    task automatic t_serial();
        int d;
        int t_f;
        int t;
        int t2;
        int dd;
        int hi;
        for (int c = 0; c < 4; c++) begin
            wr_cfg({1'b0, 3'b010, 2'(c), 2'b11}, t_f);
            dd = 8 >> c;
            meas(S_RISE, d); chk("R4", "rise interval N=3", d, 3 * dd);
            wait_pulse(S_RISE, t);
            if (dd == 1) begin
                chk("R7", "fall with rise D=1", int'(sclk_fall_o), 1);
            end else begin
                wait_pulse(S_FALL, t2);
                chk("R7", "fall offset", t2 - t, 3 * dd / 2);
            end
            wait_pulse(S_RISE, t);
            hi = 0;
            for (int i = 0; i < 3 * dd; i++) begin
                @(negedge clk);
                hi += int'(sclk_o);
            end
            chk("R7", "sclk high cycles", hi, (dd >= 2) ? 3 * dd / 2 : 3 * dd);
        end
    endtask

    task automatic t_sample();
        int d;
        int t_f;
        int t;
        for (int c = 0; c < 4; c++) begin
            wr_cfg({1'b0, 3'b001, 2'b11, 2'(c)}, t_f);
            meas(S_FS, d); chk("R5", "strobe interval N=2", d, 2 * (2048 >> c));
            chk("R6", "rise with strobe", int'(sclk_rise_o), 1);
            wait_pulse(S_FS, t);
            chk("R6", "rise with next strobe", int'(sclk_rise_o), 1);
        end
    endtask

    task automatic t_apply();
        int t_f;
        int d;
        wr_cfg(8'h03, t_f);
        wr_cfg(8'h0F, t_f);
        chk("R8", "old pattern at fall (no rise)", int'(sclk_rise_o), 0);
        @(negedge clk);
        chk("R9", "rise right after fall", int'(sclk_rise_o), 1);
        chk("R9", "strobe right after fall", int'(fs_strobe_o), 1);
        @(negedge clk);
        chk("R8", "new D=1 rise next cycle", int'(sclk_rise_o), 1);
        // pending replacement: second write overrides the first
        wr_cfg(8'h03, t_f);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h07;
        @(negedge clk);
        wr_data = 8'h0B;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (20) @(negedge clk);
        meas(S_RISE, d); chk("R8", "last write wins, D=2", d, 2);
    endtask

    task automatic t_serial_only();
        int t_f;
        wr_cfg(8'h13, t_f);
        repeat (40) @(negedge clk);
        wr_cfg(8'h1F, t_f);
        @(negedge clk);
        chk("R9", "no master tick at t_f+1", int'(mclk_en_o), 0);
        chk("R9", "no rise at t_f+1", int'(sclk_rise_o), 0);
        @(negedge clk);
        chk("R9", "tick at t_f+2", int'(mclk_en_o), 1);
        chk("R9", "rise at t_f+2", int'(sclk_rise_o), 1);
        chk("R9", "strobe at t_f+2", int'(fs_strobe_o), 1);
    endtask

    task automatic t_same();
        int t_f;
        int seen;
        wr_cfg(8'h03, t_f);
        repeat (20) @(negedge clk);
        for (int pass = 0; pass < 2; pass++) begin
            wr_cfg((pass == 0) ? 8'h03 : 8'h83, t_f);
            seen = 0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                seen += int'(sclk_rise_o);
            end
            chk("R10", "no rise t_f+1..3", seen, 0);
            @(negedge clk);
            chk("R10", "regular rise at t_f+4", int'(sclk_rise_o), 1);
        end
    endtask

    initial begin
        t_reset();
        t_master();
        t_serial();
        t_sample();
        t_apply();
        t_serial_only();
        t_same();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: run time exceeded, actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule